// File: doc/BRIEF.md
# Self-Triggered Hold and Timestamp Sequencer

This block holds the digital trigger and sampling control for a 64-channel photosensor front end. Each channel presents one discriminator bit. Any hit on an armed channel raises an enable for a shared, wired-OR trigger line between chips. A single sample-and-hold strobe is produced in one of three ways:
- directly from an external strobe input,
- after a programmed delay that follows the block's own first hit,
- after the same delay that follows a trigger asserted on the shared line by another chip.

Every channel has a saturating counter. The counter starts on that channel's first hit and freezes at the hold strobe. The value therefore measures how long before the hold the channel fired. In local-trigger mode the earliest channel always reads the programmed delay, and later channels read less.

Once the hold fires, the frozen time, the hit flag and a sampled charge word of every channel are read out one channel per transfer. Both streams advance together under a valid/ready handshake, and a channel index goes with each transfer. A clear pulse, accepted only after the last channel, re-arms the block. Mode and delay come from a configuration load.

Top module: `trig_hold_seq`

## Requirements
- R1: After reset, `hold_out`, `rd_valid` and `trig_drive` are low. The configured mode is external (0) and the delay is 0.
- R2: In any mode, a hit on an armed channel sets `trig_drive` high in the next cycle. It stays high until the hold strobe, and it is low in the cycle where `hold_out` is high.
- R3: `cfg_mode` encodes the hold source: 0 or 3 means external, 1 means local trigger, 2 means peer trigger. The values are loaded on a `cfg_load` cycle. In external mode, `ext_hold` sampled high while armed makes `hold_out` high in the next cycle. Hits alone never cause a hold in this mode.
- R4: In local mode, let the first hit be sampled at edge k and let the delay be D. The hold is taken at edge k+D+1, so `hold_out` is high in the cycle after that edge.
- R5: In peer mode, `trig_line_in` sampled high while `trig_drive` is low starts the delay with the same timing as R4. The line is ignored while the block is driving it, so the block's own hits never produce a hold in this mode.
- R6: A channel whose first hit is sampled at edge s, with the hold taken at edge f, reports time f-1-s and hit flag 1. In local mode the first channel therefore reports D, and a channel hitting j cycles later reports D-j.
- R7: A repeated hit does not restart a counter. A hit sampled at or after the hold edge is ignored. A channel that did not hit reports time 0 and hit flag 0.
- R8: The 12-bit time saturates at 4095.
- R9: The charge word of each channel is captured at the hold edge. Later changes of `ch_charge` do not alter the value read out.
- R10: After the hold, `rd_valid` is high and `rd_chan` steps 0,1,...,63. It advances only on a cycle where `rd_valid` and `rd_ready` are both high and is stable otherwise. `rd_valid` falls after channel 63 is accepted.
- R11: `clear` acts only after the readout is complete. There it re-arms the block with all channels zeroed. A clear, or a hit, during the readout has no effect on the data read out.
- R12: `hold_out` is a single-cycle pulse. In that cycle `rd_valid` is high and `rd_chan` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load `cfg_mode` and `cfg_delay` |
| cfg_mode | input | 2 | Hold source selection |
| cfg_delay | input | 10 | Hold delay in cycles |
| ch_hit | input | 64 | Per-channel discriminator bits |
| ch_charge | input | 512 | Per-channel charge words, 8 bits each, channel i at bits 8i+7..8i |
| ext_hold | input | 1 | External hold strobe |
| trig_line_in | input | 1 | Sensed level of the shared trigger line |
| trig_drive | output | 1 | Enable to pull the shared trigger line |
| hold_out | output | 1 | Hold strobe pulse |
| clear | input | 1 | Re-arm after readout |
| rd_ready | input | 1 | Readout consumer ready |
| rd_valid | output | 1 | Readout word valid |
| rd_chan | output | 6 | Channel index of the readout word |
| rd_hit | output | 1 | Channel hit flag |
| rd_time | output | 12 | Channel time stamp |
| rd_charge | output | 8 | Channel charge word |

## Verification
The assertions watch the readout protocol on every cycle. They check the single-cycle hold pulse, its alignment with channel 0, stalls and single steps of the channel index, and the drop of valid after channel 63. They also check that the trigger enable is released at the hold and that an unhit channel never shows a nonzero time. The hold timing relative to a hit or a peer trigger, the per-channel time values, saturation, charge capture and the ignoring of hits and clears all depend on the stimulus history, so only the bench scenarios show them. Those scenarios include a table of delay and hit-spacing cases in local mode.

// File: rtl/ths_pkg.sv
`timescale 1ns/1ps
package ths_pkg;

    parameter int TIME_W = 12;
    parameter int DLY_W  = 10;
    parameter int CHG_W  = 8;

    typedef enum logic [1:0] {
        HM_EXT     = 2'd0,
        HM_LOCAL   = 2'd1,
        HM_PEER    = 2'd2,
        HM_EXT_ALT = 2'd3
    } hold_mode_e;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_DELAY = 2'd1,
        ST_READ  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        logic [TIME_W-1:0] stamp;
        logic [CHG_W-1:0]  charge;
    } chan_rec_t;

    function automatic logic [TIME_W-1:0] sat_inc(input logic [TIME_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/ths_chan_timer.sv
`timescale 1ns/1ps
module ths_chan_timer
    import ths_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 run,
    input  logic                 fire,
    input  logic                 hit,
    input  logic [CHG_W-1:0]     charge_in,
    output chan_rec_t            rec
);

    chan_rec_t rec_q;

    // Counter starts on first hit, counts while armed, freezes at the hold edge.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rec_q <= '0;
        end else if (fire) begin
            rec_q.charge <= charge_in;
        end else if (run) begin
            if (rec_q.hit) begin
                rec_q.stamp <= sat_inc(rec_q.stamp);
            end else if (hit) begin
                rec_q.hit <= 1'b1;
            end
        end
    end

    assign rec = rec_q;

endmodule

// File: rtl/ths_hold_ctrl.sv
`timescale 1ns/1ps
module ths_hold_ctrl
    import ths_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_mode,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             any_hit,
    input  logic             ext_hold,
    input  logic             trig_line_in,
    input  logic             clear,
    input  logic             read_done,
    output logic             fire,
    output logic             run,
    output logic             clr_pulse,
    output logic             hold_out,
    output logic             trig_drive
);

    hold_mode_e       mode_q;
    logic [DLY_W-1:0] delay_q;
    logic [DLY_W-1:0] cnt_q;
    seq_state_e       state_q;
    logic             hold_q;
    logic             drive_q;

    logic armed;
    logic ext_sel;
    logic start;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= HM_EXT;
            delay_q <= '0;
        end else if (cfg_load) begin
            mode_q  <= hold_mode_e'(cfg_mode);
            delay_q <= cfg_delay;
        end
    end

    always_comb begin
        armed   = (state_q == ST_ARMED) || (state_q == ST_DELAY);
        ext_sel = (mode_q == HM_EXT) || (mode_q == HM_EXT_ALT);
        start   = (state_q == ST_ARMED) &&
                  (((mode_q == HM_LOCAL) && any_hit) ||
                   ((mode_q == HM_PEER) && trig_line_in && !drive_q));
        fire    = ((state_q == ST_ARMED) && ext_sel && ext_hold) ||
                  ((state_q == ST_DELAY) && (cnt_q == '0));
        run       = armed && !fire;
        clr_pulse = (state_q == ST_DONE) && clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_ARMED: begin
                    if (fire) begin
                        state_q <= ST_READ;
                    end else if (start) begin
                        state_q <= ST_DELAY;
                        cnt_q   <= delay_q;
                    end
                end
                ST_DELAY: begin
                    if (fire) state_q <= ST_READ;
                    else      cnt_q   <= cnt_q - 1'b1;
                end
                ST_READ: begin
                    if (read_done) state_q <= ST_DONE;
                end
                default: begin
                    if (clear) state_q <= ST_ARMED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            hold_q <= fire;
            if (fire)                drive_q <= 1'b0;
            else if (run && any_hit) drive_q <= 1'b1;
        end
    end

    assign hold_out   = hold_q;
    assign trig_drive = drive_q;

endmodule

// File: rtl/ths_readout.sv
`timescale 1ns/1ps
module ths_readout
    import ths_pkg::*;
#(
    parameter int NUM_CH   = 64,
    localparam int IDX_W   = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fire,
    input  chan_rec_t [NUM_CH-1:0]       recs,
    input  logic                         rd_ready,
    output logic                         rd_valid,
    output logic [IDX_W-1:0]             rd_chan,
    output logic                         rd_hit,
    output logic [TIME_W-1:0]            rd_time,
    output logic [CHG_W-1:0]             rd_charge,
    output logic                         done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    logic             valid_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    chan_rec_t        sel;

    assign accept = valid_q && rd_ready;
    assign done   = accept && (idx_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (fire) begin
            valid_q <= 1'b1;
            idx_q   <= '0;
        end else if (accept) begin
            if (idx_q == LAST) valid_q <= 1'b0;
            else               idx_q   <= idx_q + 1'b1;
        end
    end

    assign sel       = recs[idx_q];
    assign rd_valid  = valid_q;
    assign rd_chan   = idx_q;
    assign rd_hit    = sel.hit;
    assign rd_time   = sel.stamp;
    assign rd_charge = sel.charge;

endmodule

// File: rtl/trig_hold_seq.sv
`timescale 1ns/1ps
module trig_hold_seq
    import ths_pkg::*;
#(
    parameter int NUM_CH  = 64,
    localparam int IDX_W  = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_load,
    input  logic [1:0]              cfg_mode,
    input  logic [DLY_W-1:0]        cfg_delay,
    input  logic [NUM_CH-1:0]       ch_hit,
    input  logic [NUM_CH*CHG_W-1:0] ch_charge,
    input  logic                    ext_hold,
    input  logic                    trig_line_in,
    output logic                    trig_drive,
    output logic                    hold_out,
    input  logic                    clear,
    input  logic                    rd_ready,
    output logic                    rd_valid,
    output logic [IDX_W-1:0]        rd_chan,
    output logic                    rd_hit,
    output logic [TIME_W-1:0]       rd_time,
    output logic [CHG_W-1:0]        rd_charge
);

    logic fire;
    logic run;
    logic clr_pulse;
    logic read_done;
    chan_rec_t [NUM_CH-1:0] recs;

    ths_hold_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_mode     (cfg_mode),
        .cfg_delay    (cfg_delay),
        .any_hit      (|ch_hit),
        .ext_hold     (ext_hold),
        .trig_line_in (trig_line_in),
        .clear        (clear),
        .read_done    (read_done),
        .fire         (fire),
        .run          (run),
        .clr_pulse    (clr_pulse),
        .hold_out     (hold_out),
        .trig_drive   (trig_drive)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        ths_chan_timer timer_i (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr_pulse),
            .run       (run),
            .fire      (fire),
            .hit       (ch_hit[i]),
            .charge_in (ch_charge[i*CHG_W +: CHG_W]),
            .rec       (recs[i])
        );
    end

    ths_readout #(.NUM_CH(NUM_CH)) rdo_i (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .recs      (recs),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_chan   (rd_chan),
        .rd_hit    (rd_hit),
        .rd_time   (rd_time),
        .rd_charge (rd_charge),
        .done      (read_done)
    );

endmodule

// File: rtl/ths_seq_checker.sv
`timescale 1ns/1ps
module ths_seq_checker
    import ths_pkg::*;
#(
    parameter int NUM_CH = 64,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_out,
    input logic              trig_drive,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [IDX_W-1:0]  rd_chan,
    input logic              rd_hit,
    input logic [TIME_W-1:0] rd_time
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    assert_hold_single_R12: assert property (@(posedge clk) disable iff (rst)
        hold_out |=> !hold_out);

    assert_hold_starts_read_R12: assert property (@(posedge clk) disable iff (rst)
        hold_out |-> (rd_valid && rd_chan == '0));

    assert_drive_released_R2: assert property (@(posedge clk) disable iff (rst)
        hold_out |-> !trig_drive);

    assert_chan_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_chan)));

    assert_chan_step_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && rd_chan != LAST) |=>
        (rd_valid && rd_chan == IDX_W'($past(rd_chan) + 1'b1)));

    assert_last_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && rd_chan == LAST) |=> !rd_valid);

    assert_unhit_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_hit) |-> (rd_time == '0));

endmodule

bind trig_hold_seq ths_seq_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .hold_out   (hold_out),
    .trig_drive (trig_drive),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_chan    (rd_chan),
    .rd_hit     (rd_hit),
    .rd_time    (rd_time)
);

// File: tb/trig_hold_seq_tb_top.sv
`timescale 1ns/1ps
module trig_hold_seq_tb_top;
    import ths_pkg::*;

    localparam int NCH = 64;
    localparam int NV  = 5;
    // delay, chA, chB, gap, expA, expB, expB_hit
    localparam int VEC [NV][7] = '{
        '{20,   3, 40,    5,   20, 15, 1},
        '{0,    0, 63,    0,    0,  0, 1},
        '{7,   12, 13,    7,    7,  0, 1},
        '{7,   12, 13,    8,    7,  0, 0},
        '{1023, 63, 0, 1000, 1023, 23, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic [NCH-1:0] ch_hit = '0;
    logic [NCH*CHG_W-1:0] ch_charge = '0;
    logic ext_hold = 1'b0;
    logic peer_line = 1'b0;
    logic trig_line_in;
    logic trig_drive, hold_out, clear = 1'b0, rd_ready = 1'b0, rd_valid;
    logic [5:0] rd_chan;
    logic rd_hit;
    logic [TIME_W-1:0] rd_time;
    logic [CHG_W-1:0] rd_charge;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    int got_time [NCH];
    int got_hit  [NCH];
    int got_chg  [NCH];

    assign trig_line_in = trig_drive | peer_line;

    always #10 clk = ~clk;

    trig_hold_seq dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_delay(cfg_delay), .ch_hit(ch_hit), .ch_charge(ch_charge),
        .ext_hold(ext_hold), .trig_line_in(trig_line_in), .trig_drive(trig_drive),
        .hold_out(hold_out), .clear(clear), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_chan(rd_chan), .rd_hit(rd_hit), .rd_time(rd_time), .rd_charge(rd_charge)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_cfg(input int mode, input int dly);
        @(negedge clk);
        cfg_mode = mode[1:0]; cfg_delay = dly[DLY_W-1:0]; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic read_all(input bit stall);
        int n = 0;
        int guard = 0;
        while (n < NCH && guard < 3000) begin
            @(negedge clk);
            guard++;
            rd_ready = stall ? (guard % 3 != 0) : 1'b1;
            if (rd_valid && rd_ready) begin
                if (rd_chan != n[5:0])
                    check(0, "R10", "channel order", int'(rd_chan), n);
                got_time[n] = int'(rd_time);
                got_hit[n]  = int'(rd_hit);
                got_chg[n]  = int'(rd_charge);
                n++;
            end
        end
        check(n == NCH, "R10", "channels read", n, NCH);
        @(negedge clk);
        rd_ready = 1'b0;
        check(!rd_valid, "R10", "valid after last", int'(rd_valid), 0);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    function automatic logic [NCH*CHG_W-1:0] charge_pattern();
        logic [NCH*CHG_W-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*CHG_W +: CHG_W] = CHG_W'(i * 3 + 1);
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit seen;
        do_reset();
        // R1: reset state
        check(!hold_out,   "R1", "hold_out", int'(hold_out), 0);
        check(!rd_valid,   "R1", "rd_valid", int'(rd_valid), 0);
        check(!trig_drive, "R1", "trig_drive", int'(trig_drive), 0);

        // R1/R3: default external mode, hits alone never hold
        @(negedge clk); ch_hit[2] = 1'b1;
        seen = 1'b0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk); ch_hit = '0;
            seen |= hold_out;
            if (i == 1) check(trig_drive, "R2", "drive after hit", int'(trig_drive), 1);
        end
        check(!seen, "R3", "no hold from hits in external mode", int'(seen), 0);
        @(negedge clk); ext_hold = 1'b1;
        @(negedge clk); ext_hold = 1'b0;
        check(hold_out, "R3", "hold after ext strobe", int'(hold_out), 1);
        check(!trig_drive, "R2", "drive released at hold", int'(trig_drive), 0);
        read_all(0);
        check(got_time[2] == 30 && got_hit[2] == 1, "R6", "ext time ch2", got_time[2], 30);
        check(got_hit[3] == 0 && got_time[3] == 0, "R7", "unhit ch3", got_time[3], 0);
        pulse_clear();

        // R4: local hold timing
        load_cfg(1, 5);
        @(negedge clk); ch_hit[9] = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk); ch_hit = '0;
            if (i == 6) check(!hold_out, "R4", "hold before D+1", int'(hold_out), 0);
            if (i == 7) check(hold_out,  "R4", "hold at D+1", int'(hold_out), 1);
            if (i == 8) check(!hold_out, "R12", "hold single cycle", int'(hold_out), 0);
        end
        read_all(0);
        check(got_time[9] == 5, "R6", "local first channel", got_time[9], 5);
        pulse_clear();

        // R6/R7: table of local-mode cases
        for (int v = 0; v < NV; v++) begin
            int other;
            load_cfg(1, VEC[v][0]);
            for (int t = 0; t <= VEC[v][3]; t++) begin
                @(negedge clk);
                ch_hit = '0;
                if (t == 0) ch_hit[VEC[v][1]] = 1'b1;
                if (t == VEC[v][3]) ch_hit[VEC[v][2]] = 1'b1;
            end
            @(negedge clk); ch_hit = '0;
            read_all(0);
            other = 30 + v;
            check(got_time[VEC[v][1]] == VEC[v][4] && got_hit[VEC[v][1]] == 1,
                  "R6", "table first channel", got_time[VEC[v][1]], VEC[v][4]);
            check(got_time[VEC[v][2]] == VEC[v][5] && got_hit[VEC[v][2]] == VEC[v][6],
                  "R7", "table second channel", got_time[VEC[v][2]], VEC[v][5]);
            check(got_hit[other] == 0 && got_time[other] == 0,
                  "R7", "table idle channel", got_time[other], 0);
            pulse_clear();
        end

        // R7/R9/R11: re-hit, charge capture, clear and hits during readout
        load_cfg(1, 3);
        ch_charge = charge_pattern();
        @(negedge clk); ch_hit[20] = 1'b1;
        @(negedge clk); ch_hit = '0;
        @(negedge clk); ch_hit[20] = 1'b1;
        @(negedge clk); ch_hit = '0;
        @(negedge clk);
        @(negedge clk);
        check(hold_out, "R4", "hold with D=3", int'(hold_out), 1);
        ch_charge = {NCH{8'hAA}}; ch_hit[21] = 1'b1; clear = 1'b1;
        @(negedge clk); ch_hit = '0; clear = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_valid && rd_chan == 0, "R11", "clear ignored during readout",
              int'(rd_valid), 1);
        read_all(1);
        check(got_time[20] == 3, "R7", "re-hit no restart", got_time[20], 3);
        check(got_hit[21] == 0, "R11", "hit during readout ignored", got_hit[21], 0);
        check(got_chg[20] == 61, "R9", "charge ch20", got_chg[20], 61);
        check(got_chg[63] == 190, "R9", "charge ch63", got_chg[63], 190);
        pulse_clear();

        // R8: saturation
        load_cfg(0, 0);
        @(negedge clk); ch_hit[1] = 1'b1;
        @(negedge clk); ch_hit = '0;
        repeat (4200) @(negedge clk);
        ext_hold = 1'b1;
        @(negedge clk); ext_hold = 1'b0;
        read_all(0);
        check(got_time[1] == 4095, "R8", "saturated time", got_time[1], 4095);
        pulse_clear();

        // R5: peer trigger
        load_cfg(2, 4);
        @(negedge clk); peer_line = 1'b1;
        @(negedge clk); peer_line = 1'b0; ch_hit[7] = 1'b1;
        @(negedge clk); ch_hit = '0;
        @(negedge clk); ch_hit[8] = 1'b1;
        @(negedge clk); ch_hit = '0;
        @(negedge clk);
        check(!hold_out, "R5", "peer hold not early", int'(hold_out), 0);
        @(negedge clk);
        check(hold_out, "R5", "peer hold at D+1", int'(hold_out), 1);
        read_all(0);
        check(got_time[7] == 3, "R5", "peer ch7 time", got_time[7], 3);
        check(got_time[8] == 1, "R6", "peer ch8 time", got_time[8], 1);
        pulse_clear();

        // R5: own drive on the line never triggers itself
        @(negedge clk); ch_hit[30] = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); ch_hit = '0;
            seen |= hold_out;
        end
        check(!seen, "R5", "no self trigger", int'(seen), 0);
        check(trig_drive, "R2", "drive held while armed", int'(trig_drive), 1);
        do_reset();
        check(!trig_drive, "R1", "drive after reset", int'(trig_drive), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule